// File: doc/BRIEF.md
# Sequential HI/LO Multiply-Divide Unit

This block is a 32-bit arithmetic unit beside an integer pipeline that keeps its results in two dedicated registers, HI and LO, not in the general register file. A start command carries an operation code and two operands. A multiply finishes in one clock: the 64-bit product is split so that LO holds the lower half and HI holds the upper half. A divide runs as a restoring shift-subtract loop, one quotient bit per clock. It leaves the quotient in LO and the remainder in HI.

Both operations have a signed form and an unsigned form. For the signed forms the unit takes the magnitudes of the operands, works on those, and then applies the result signs at the end. While a divide is in progress the unit raises a busy flag. Commands that arrive during that time are dropped. The pipeline uses the busy flag to decide when it may read the two result ports, which serve the move-from-HI and move-from-LO instructions. Stalling the pipeline is the job of the surrounding logic.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, busy_o is 0 and hi_o and lo_o are both 0.
- R2: op_i bit 1 selects the operation (0 = multiply, 1 = divide) and op_i bit 0 selects signedness (1 = signed two's complement, 0 = unsigned). A command is accepted at a rising clock edge where start_i is 1 and busy_o is 0.
- R3: An accepted unsigned multiply places the 64-bit product in {hi_o, lo_o} after that same edge. busy_o stays 0.
- R4: An accepted signed multiply places the 64-bit two's-complement product in {hi_o, lo_o} after that same edge. busy_o stays 0.
- R5: An accepted unsigned divide with a nonzero divisor ends with lo_o = a_i / b_i and hi_o = a_i % b_i.
- R6: A signed divide with a nonzero divisor truncates the quotient toward zero, and the remainder takes the sign of the dividend. The case 0x80000000 / -1 gives quotient 0x80000000 and remainder 0.
- R7: After a divide is accepted, busy_o is 1 for exactly 32 clock cycles. HI and LO take the divide result at the same edge where busy_o returns to 0.
- R8: hi_o and lo_o do not change while busy_o is 1 (apart from the finishing edge), and they do not change in idle cycles with no accepted command.
- R9: A start_i given while busy_o is 1 is ignored. It changes neither the running divide's result nor its duration.
- R10: A divide by zero raises no error. It completes in the same 32 cycles, and the HI and LO values it leaves are unspecified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command strobe |
| op_i | input | 2 | Bit 1: divide/multiply; bit 0: signed/unsigned |
| a_i | input | 32 | First operand (multiplicand or dividend) |
| b_i | input | 32 | Second operand (multiplier or divisor) |
| busy_o | output | 1 | Divide in progress |
| hi_o | output | 32 | HI register: product upper half or remainder |
| lo_o | output | 32 | LO register: product lower half or quotient |

## Verification
Multiplies are tried with small values, with all-ones operands, and with mixed signs. Running the same bit patterns as signed and as unsigned shows whether the sign extension is applied only in the signed mode. Divides cover the four sign combinations with an odd dividend, a dividend smaller than the divisor, a divisor of one, and the most negative dividend over minus one. These separate truncation toward zero from floor rounding, and show which operand sets the remainder's sign. Further cases are a divide by zero followed by a normal command, starts held high through a whole divide, and a stream of pseudo-random operands. These show that commands during busy are dropped and that a new command is accepted right after busy clears.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    localparam int OPB_DIV = 1;
    localparam int OPB_SGN = 0;
    localparam int DIV_STEPS_PER_BIT = 1;
endpackage

// File: rtl/md_cond_neg.sv
module md_cond_neg #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic         neg_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        res_o = neg_i ? (~val_i + W'(1)) : val_i;
    end
endmodule

// File: rtl/md_mul_core.sv
module md_mul_core #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           sgn_i,
    output logic [2*W-1:0] prod_o
);
    localparam int XW = W + 1;
    logic signed [XW-1:0]   a_x;
    logic signed [XW-1:0]   b_x;
    logic signed [2*XW-1:0] full;

    always_comb begin
        a_x    = {sgn_i & a_i[W-1], a_i};
        b_x    = {sgn_i & b_i[W-1], b_i};
        full   = a_x * b_x;
        prod_o = full[2*W-1:0];
    end
endmodule

// File: rtl/md_div_step.sv
module md_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quot_i,
    input  logic [W-1:0] dvsr_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quot_o
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        trial  = {rem_i, quot_i[W-1]};
        diff   = trial - {1'b0, dvsr_i};
        fits   = (trial >= {1'b0, dvsr_i});
        rem_o  = fits ? diff[W-1:0] : trial[W-1:0];
        quot_o = {quot_i[W-2:0], fits};
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             busy_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    import muldiv_pkg::*;

    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] step;
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] quot;
        logic [WIDTH-1:0] dvsr;
        logic             qneg;
        logic             rneg;
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
    } md_state_t;

    md_state_t st_d, st_q;

    logic             is_sgn;
    logic [1:0]       opnd_neg;
    logic [WIDTH-1:0] opnd_val [2];
    logic [WIDTH-1:0] opnd_mag [2];
    logic [2*WIDTH-1:0] prod;
    logic [WIDTH-1:0] rem_nx, quot_nx;
    logic [WIDTH-1:0] quot_fix, rem_fix;

    assign is_sgn      = op_i[OPB_SGN];
    assign opnd_val[0] = a_i;
    assign opnd_val[1] = b_i;

    for (genvar gi = 0; gi < 2; gi++) begin : g_mag
        assign opnd_neg[gi] = is_sgn & opnd_val[gi][WIDTH-1];
        md_cond_neg #(.W(WIDTH)) u_mag (
            .val_i (opnd_val[gi]),
            .neg_i (opnd_neg[gi]),
            .res_o (opnd_mag[gi])
        );
    end

    md_mul_core #(.W(WIDTH)) u_mul (
        .a_i    (a_i),
        .b_i    (b_i),
        .sgn_i  (is_sgn),
        .prod_o (prod)
    );

    md_div_step #(.W(WIDTH)) u_step (
        .rem_i  (st_q.rem),
        .quot_i (st_q.quot),
        .dvsr_i (st_q.dvsr),
        .rem_o  (rem_nx),
        .quot_o (quot_nx)
    );

    md_cond_neg #(.W(WIDTH)) u_qfix (
        .val_i (quot_nx),
        .neg_i (st_q.qneg),
        .res_o (quot_fix)
    );

    md_cond_neg #(.W(WIDTH)) u_rfix (
        .val_i (rem_nx),
        .neg_i (st_q.rneg),
        .res_o (rem_fix)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.rem  = rem_nx;
            st_d.quot = quot_nx;
            st_d.step = st_q.step + CNT_W'(DIV_STEPS_PER_BIT);
            if (st_q.step == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.step = '0;
                st_d.lo   = quot_fix;
                st_d.hi   = rem_fix;
            end
        end else if (start_i) begin
            if (op_i[OPB_DIV]) begin
                st_d.busy = 1'b1;
                st_d.step = '0;
                st_d.rem  = '0;
                st_d.quot = opnd_mag[0];
                st_d.dvsr = opnd_mag[1];
                st_d.qneg = opnd_neg[0] ^ opnd_neg[1];
                st_d.rneg = opnd_neg[0];
            end else begin
                st_d.hi = prod[2*WIDTH-1:WIDTH];
                st_d.lo = prod[WIDTH-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign hi_o   = st_q.hi;
    assign lo_o   = st_q.lo;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [1:0]       op_i,
    input logic             busy_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o
);
    localparam int RUN_W = $clog2(WIDTH) + 2;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + RUN_W'(1);
        else             run_q <= '0;
    end

    a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(WIDTH));

    a_r7_busy_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q == RUN_W'(WIDTH)));

    a_r2_div_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i[1]) |=> busy_o);

    a_r3_mul_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !op_i[1]) |=> !busy_o);

    a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || ($stable(hi_o) && $stable(lo_o))));

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(hi_o) && $stable(lo_o)));

    a_r9_busy_rise_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i && op_i[1]));
endmodule

bind muldiv_unit muldiv_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .busy_o  (busy_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        busy_o;
    logic [31:0] hi_o, lo_o;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";
    bit cmp_en = 1'b0;

    // reference model state
    bit          m_busy = 1'b0;
    int          m_cnt  = 0;
    logic [31:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
    bit          m_unk = 1'b0, p_unk = 1'b0;
    logic [31:0] rng = 32'h1234_5679;

    always #2 clk = ~clk;

    muldiv_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    always @(posedge clk) begin
        longint unsigned up;
        longint sp, sa, sb;
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_hi = '0; m_lo = '0; m_unk = 0;
        end else if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_busy = 0; m_hi = p_hi; m_lo = p_lo; m_unk = p_unk;
            end
        end else if (start_i) begin
            if (!op_i[1]) begin
                if (op_i[0]) begin
                    sp = longint'($signed(a_i)) * longint'($signed(b_i));
                    up = longint'(sp);
                end else begin
                    up = longint'(a_i) * longint'(b_i);
                end
                m_hi = up[63:32]; m_lo = up[31:0]; m_unk = 0;
            end else begin
                m_busy = 1; m_cnt = 32; p_unk = (b_i == 0);
                if (b_i == 0) begin
                    p_hi = '0; p_lo = '0;
                end else if (op_i[0]) begin
                    sa = longint'($signed(a_i)); sb = longint'($signed(b_i));
                    p_lo = 32'(sa / sb); p_hi = 32'(sa % sb);
                end else begin
                    p_lo = a_i / b_i; p_hi = a_i % b_i;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (busy_o !== m_busy) begin
                fails++;
                $display("FAIL %s: busy_o=%0b expected %0b", tag, busy_o, m_busy);
            end
            if (!m_unk) begin
                checks++;
                if (hi_o !== m_hi || lo_o !== m_lo) begin
                    fails++;
                    $display("FAIL %s: hi/lo=%h/%h expected %h/%h",
                             tag, hi_o, lo_o, m_hi, m_lo);
                end
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] b, input string t);
        @(negedge clk);
        tag = t; start_i = 1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 0;
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_en = 1;
        tag = "R1";
        repeat (2) @(negedge clk);
        // multiplies
        issue(2'b00, 32'd6, 32'd7, "R3");
        issue(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
        issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
        issue(2'b01, 32'hFFFF_FFFD, 32'd5, "R4");
        issue(2'b01, 32'h8000_0000, 32'h8000_0000, "R4");
        // unsigned divides
        issue(2'b10, 32'd100, 32'd7, "R5");
        issue(2'b10, 32'hFFFF_FFFF, 32'd1, "R5");
        issue(2'b10, 32'd5, 32'd9, "R5");
        issue(2'b10, 32'hFFFF_FFF9, 32'd2, "R5");
        // signed divides
        issue(2'b11, 32'hFFFF_FFF9, 32'd2, "R6");
        issue(2'b11, 32'd7, 32'hFFFF_FFFE, "R6");
        issue(2'b11, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R6");
        issue(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
        // divide by zero, then normal command restores checking
        issue(2'b11, 32'd1234, 32'd0, "R10");
        issue(2'b00, 32'd3, 32'd3, "R10");
        // start held / re-issued while busy
        @(negedge clk);
        tag = "R9"; start_i = 1; op_i = 2'b10; a_i = 32'd1000; b_i = 32'd3;
        @(negedge clk);
        op_i = 2'b00; a_i = 32'd9; b_i = 32'd9;
        repeat (10) @(negedge clk);
        op_i = 2'b11; a_i = 32'hFFFF_FF00; b_i = 32'd5;
        while (m_busy) @(negedge clk);
        tag = "R7";
        while (m_busy || start_i) begin
            start_i = 0;
            @(negedge clk);
        end
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        tag = "R8";
        repeat (5) @(negedge clk);
        // pseudo-random stream
        for (int i = 0; i < 200; i++) begin
            logic [31:0] ra, rb;
            rng = nxt(rng); ra = rng;
            rng = nxt(rng); rb = (i % 4 == 0) ? (rng >> (rng[4:0])) : rng;
            if (rb == 0) rb = 32'd1;
            issue(2'(i % 4), ra, rb, (i % 4 < 2) ? "R4" : "R6");
        end
        cmp_en = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule